// File: doc/BRIEF.md
# PS/2 Host-Side Serial Transceiver

This block connects a host controller to a keyboard or pointing device over a two-wire serial link. Both wires are open drain. The device normally generates the clock. The block never drives a line high. It only asserts a "drive low" output for each wire and reads the resolved line levels back through a two-flop synchroniser and a hold-count glitch filter.

In the receive direction, the block collects an eleven-bit frame and checks the odd parity. It then presents the byte for one cycle, with a parity-error flag beside it. If the link stalls in the middle of a frame, the frame is dropped and a receive-timeout pulse is raised.

In the transmit direction, the block accepts one byte and performs the request-to-send sequence. It holds the clock low for at least 100 µs, pulls data low as the start bit and releases the clock. It then shifts the byte out on clocks generated by the device. Finally it waits for the device to acknowledge. No further byte is accepted until that acknowledge arrives or the transfer fails; a failure is reported as a transmit-timeout pulse. All timing is derived from the `CLK_HZ` parameter.

Top module: `ps2_host_xcvr`

## Requirements
- R1: A received frame consists of a start bit (0), eight data bits with the least significant bit first, a parity bit and a stop bit (1). Each bit is captured on a falling edge of the filtered clock. After the stop bit, `rx_valid` is high for exactly one cycle while `rx_data` holds the byte.
- R2: `rx_parity_err` is valid together with `rx_valid`. It is 1 when the eight data bits plus the parity bit contain an even number of ones, and 0 when they contain an odd number.
- R3: A frame whose stop bit is 0 produces no `rx_valid`.
- R4: The receive-timeout counter restarts on every clock edge. If `RX_TO_US` microseconds pass without an edge during a frame, the partial frame is discarded, `rx_timeout_err` pulses for one cycle, and the next complete frame is received normally.
- R5: A pulse on the clock input shorter than `FILT_LEN` system cycles has no effect on reception.
- R6: A byte is accepted on `tx_valid && tx_ready`. The clock output is then held low for at least 100 µs (110 µs are used). After that, the data output drives the start bit low at the moment the clock is released.
- R7: The transmitted frame is the eight data bits with the least significant bit first, then the odd parity bit, then a released stop bit. Each bit changes 10 µs after a rising clock edge, which keeps it inside the 5 to 25 µs window.
- R8: `tx_ready` stays low from the accepting cycle until the device acknowledges by holding data low on the twelfth falling clock edge, or until the transfer fails. `tx_valid` has no effect during that time. A successful acknowledge pulses `tx_done`.
- R9: The transfer fails, and `tx_timeout_err` pulses, when either of two things happens: no clock edge arrives for `TX_TO_US` microseconds, or data is high at the acknowledge edge. Both lines are then released and `tx_ready` returns high.
- R10: While `link_inhibit` is high and no transfer is in progress, the clock line is held low, `tx_ready` is low and no frame is received.
- R11: After reset, both drive-low outputs are 0, `tx_ready` is 1 and no output pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Resolved level of the link clock line |
| ps2_dat_i | input | 1 | Resolved level of the link data line |
| ps2_clk_low_o | output | 1 | 1 pulls the clock line low |
| ps2_dat_low_o | output | 1 | 1 pulls the data line low |
| link_inhibit | input | 1 | Hold the device off by keeping the clock low |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_data | input | 8 | Byte to transmit |
| tx_done | output | 1 | One-cycle pulse when the device has acknowledged |
| tx_timeout_err | output | 1 | One-cycle pulse when a transfer has failed |
| rx_valid | output | 1 | One-cycle pulse when a received byte is available |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity error for the byte on rx_data |
| rx_timeout_err | output | 1 | One-cycle pulse when a partial frame is dropped |

## Verification
A receive bit counter that slips by one shows up on the very next frame. The byte appears shifted, or no `rx_valid` appears at all, and a receive timeout fires about `RX_TO_US` later.

A transmit shift or edge-count error shows up within the same frame. The bits the device model samples differ from the offered byte or its parity, or the acknowledge is judged on the wrong edge, which turns an expected `tx_done` into `tx_timeout_err`.

A stuck busy state leaves `tx_ready` low after the transfer should have ended. Any state that fails to release the lines is visible as a clock or data line held low.

// File: rtl/ps2x_pkg.sv
package ps2x_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_INHIBIT,
    TX_XFER
  } tx_state_t;

  // Odd parity bit for a byte: makes the nine-bit total odd.
  function automatic logic odd_bit(input logic [7:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/ps2x_line_cond.sv
// Two-flop synchroniser followed by a hold-count glitch filter.
// The filtered level follows the input only after it has differed for
// FILT_LEN consecutive cycles; single-cycle edge pulses are registered.
module ps2x_line_cond #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic fall,
  output logic rise
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] HOLD_LIM = CW'(FILT_LEN - 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      lvl  <= 1'b1;
      cnt  <= '0;
      fall <= 1'b0;
      rise <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      fall <= 1'b0;
      rise <= 1'b0;
      if (s2 != lvl) begin
        if (cnt == HOLD_LIM) begin
          lvl  <= s2;
          cnt  <= '0;
          fall <= ~s2;
          rise <= s2;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R5: an accepted edge is a single pulse, never both directions at once
  a_r5_edge_single: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
  a_r5_edge_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fall && rise));
endmodule

// File: rtl/ps2x_rx.sv
// Frame receiver: start, 8 data LSB first, odd parity, stop.
module ps2x_rx #(
  parameter int TO_CYC = 6000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fall,
  input  logic       rise,
  input  logic       dat,
  output logic       valid,
  output logic [7:0] data,
  output logic       perr,
  output logic       timeout,
  output logic       busy
);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] TO_LIM = TW'(TO_CYC - 1);

  logic [3:0]    bitn;   // 0 idle, 1..9 collecting, 10 waiting for stop
  logic [8:0]    sh;
  logic [TW-1:0] tcnt;

  assign busy = (bitn != 4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitn    <= '0;
      sh      <= '0;
      tcnt    <= '0;
      valid   <= 1'b0;
      data    <= '0;
      perr    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      if (!en) begin
        bitn <= '0;
        tcnt <= '0;
      end else if (fall) begin
        tcnt <= '0;
        if (bitn == 4'd0) begin
          if (!dat) bitn <= 4'd1;
        end else if (bitn == 4'd10) begin
          bitn <= '0;
          if (dat) begin
            valid <= 1'b1;
            data  <= sh[7:0];
            perr  <= ~^sh;
          end
        end else begin
          sh   <= {dat, sh[8:1]};
          bitn <= bitn + 4'd1;
        end
      end else if (rise) begin
        tcnt <= '0;
      end else if (bitn != 4'd0) begin
        if (tcnt == TO_LIM) begin
          timeout <= 1'b1;
          bitn    <= '0;
          tcnt    <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // R1: a received byte is announced for one cycle only
  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R4: a timeout leaves the receiver idle and never coincides with a byte
  a_r4_timeout_drops: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !busy && !valid);
endmodule

// File: rtl/ps2x_tx.sv
// Host-to-device sender: inhibit, start, shift on device clock, check ack.
module ps2x_tx
  import ps2x_pkg::*;
#(
  parameter int INH_CYC = 5500,
  parameter int DLY_CYC = 500,
  parameter int TO_CYC  = 750000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       fall,
  input  logic       rise,
  input  logic       dat,
  output logic       idle,
  output logic       clk_low,
  output logic       dat_low,
  output logic       done,
  output logic       timeout
);
  localparam int MAXC = (INH_CYC > TO_CYC) ? INH_CYC : TO_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int DW   = $clog2(DLY_CYC + 1);
  localparam logic [TW-1:0] INH_LIM = TW'(INH_CYC - 1);
  localparam logic [TW-1:0] TO_LIM  = TW'(TO_CYC - 1);
  localparam logic [DW-1:0] DLY_LIM = DW'(DLY_CYC - 1);

  tx_state_t     st;
  logic [9:0]    sh;      // {stop, parity, data[7:0]}, shifted out from bit 0
  logic [3:0]    nfall, nrise;
  logic          pend;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] cnt;

  assign idle = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      sh      <= '1;
      nfall   <= '0;
      nrise   <= '0;
      pend    <= 1'b0;
      dcnt    <= '0;
      cnt     <= '0;
      clk_low <= 1'b0;
      dat_low <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (start) begin
            sh      <= {1'b1, odd_bit(din), din};
            clk_low <= 1'b1;
            dat_low <= 1'b0;
            cnt     <= '0;
            st      <= TX_INHIBIT;
          end
        end
        TX_INHIBIT: begin
          if (cnt == INH_LIM) begin
            dat_low <= 1'b1;
            clk_low <= 1'b0;
            cnt     <= '0;
            nfall   <= '0;
            nrise   <= '0;
            pend    <= 1'b0;
            st      <= TX_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (pend) begin
            if (dcnt == '0) begin
              dat_low <= ~sh[0];
              sh      <= {1'b1, sh[9:1]};
              pend    <= 1'b0;
            end else begin
              dcnt <= dcnt - 1'b1;
            end
          end
          if (fall || rise) cnt <= '0;
          else              cnt <= cnt + 1'b1;
          if (rise && (nfall > nrise) && (nrise < 4'd10)) begin
            nrise <= nrise + 4'd1;
            pend  <= 1'b1;
            dcnt  <= DLY_LIM;
          end
          if (fall) begin
            nfall <= nfall + 4'd1;
            if (nfall == 4'd11) begin
              st      <= TX_IDLE;
              dat_low <= 1'b0;
              done    <= ~dat;
              timeout <= dat;
            end
          end else if (!rise && cnt == TO_LIM) begin
            st      <= TX_IDLE;
            dat_low <= 1'b0;
            timeout <= 1'b1;
          end
        end
      endcase
    end
  end

  // R6: the clock is only released while the start bit is being driven
  a_r6_start_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_low) |-> dat_low);
  // R9: a failed transfer leaves both lines released
  a_r9_release_on_fail: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !clk_low && !dat_low && !done);
endmodule

// File: rtl/ps2_host_xcvr.sv
module ps2_host_xcvr #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int FILT_LEN = 8,
  parameter int RX_TO_US = 120,
  parameter int TX_TO_US = 15000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_low_o,
  output logic       ps2_dat_low_o,
  input  logic       link_inhibit,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       tx_done,
  output logic       tx_timeout_err,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_parity_err,
  output logic       rx_timeout_err
);
  localparam int CYC_US    = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int INH_CYC   = 110 * CYC_US;
  localparam int DLY_CYC   = 10 * CYC_US;
  localparam int RX_TO_CYC = RX_TO_US * CYC_US;
  localparam int TX_TO_CYC = TX_TO_US * CYC_US;
  localparam int NLINES    = 2;   // index 0 clock, 1 data

  logic [NLINES-1:0] pins, lvl, fall, rise;
  assign pins = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ps2x_line_cond #(.FILT_LEN(FILT_LEN)) cond_i (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .lvl (lvl[g]),
      .fall(fall[g]),
      .rise(rise[g])
    );
  end

  logic tx_idle, tx_clk_low, tx_dat_low, rx_busy, rx_en, tx_start;

  assign rx_en    = tx_idle & ~link_inhibit;
  assign tx_ready = tx_idle & ~rx_busy & ~link_inhibit;
  assign tx_start = tx_valid & tx_ready;

  ps2x_rx #(.TO_CYC(RX_TO_CYC)) rx_i (
    .clk    (clk),
    .rst    (rst),
    .en     (rx_en),
    .fall   (fall[0]),
    .rise   (rise[0]),
    .dat    (lvl[1]),
    .valid  (rx_valid),
    .data   (rx_data),
    .perr   (rx_parity_err),
    .timeout(rx_timeout_err),
    .busy   (rx_busy)
  );

  ps2x_tx #(.INH_CYC(INH_CYC), .DLY_CYC(DLY_CYC), .TO_CYC(TX_TO_CYC)) tx_i (
    .clk    (clk),
    .rst    (rst),
    .start  (tx_start),
    .din    (tx_data),
    .fall   (fall[0]),
    .rise   (rise[0]),
    .dat    (lvl[1]),
    .idle   (tx_idle),
    .clk_low(tx_clk_low),
    .dat_low(tx_dat_low),
    .done   (tx_done),
    .timeout(tx_timeout_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ps2_clk_low_o <= 1'b0;
      ps2_dat_low_o <= 1'b0;
    end else begin
      ps2_clk_low_o <= tx_clk_low | (link_inhibit & tx_idle);
      ps2_dat_low_o <= tx_dat_low;
    end
  end

  // R8: an accepted byte blocks the next one
  a_r8_accept_blocks: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_ready);
  // R10: the host inhibit reaches the clock line on the next cycle
  a_r10_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
    (link_inhibit && tx_idle) |=> ps2_clk_low_o);
  // R9: outcome pulses are exclusive
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(tx_done && tx_timeout_err));
endmodule

// File: tb/ps2_host_xcvr_tb_top.sv
// One system cycle stands for one microsecond (CLK_HZ = 1 MHz) to keep runs short.
module ps2_host_xcvr_tb_top;
  localparam int RX_TO = 150;
  localparam int TX_TO = 600;
  localparam int INH   = 110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic dev_clk_low = 1'b0, dev_dat_low = 1'b0;
  logic link_inhibit = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic clk_line, dat_line;
  logic ps2_clk_low_o, ps2_dat_low_o, tx_ready, tx_done, tx_timeout_err;
  logic rx_valid, rx_parity_err, rx_timeout_err;
  logic [7:0] rx_data;

  assign clk_line = !(ps2_clk_low_o | dev_clk_low);
  assign dat_line = !(ps2_dat_low_o | dev_dat_low);

  ps2_host_xcvr #(.CLK_HZ(1_000_000), .FILT_LEN(4), .RX_TO_US(RX_TO), .TX_TO_US(TX_TO)) dut_i (
    .clk(clk), .rst(rst), .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_low_o(ps2_clk_low_o), .ps2_dat_low_o(ps2_dat_low_o),
    .link_inhibit(link_inhibit), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_done(tx_done), .tx_timeout_err(tx_timeout_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_timeout_err(rx_timeout_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rx_n = 0, rx_to_n = 0, tx_done_n = 0, tx_to_n = 0, pulses_seen = 0;
  logic [7:0] rx_last = '0;
  logic rx_last_perr = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (rx_valid) begin rx_n++; rx_last = rx_data; rx_last_perr = rx_parity_err; end
      if (rx_timeout_err) rx_to_n++;
      if (tx_done) tx_done_n++;
      if (tx_timeout_err) tx_to_n++;
      if (rx_valid | rx_timeout_err | tx_done | tx_timeout_err) pulses_seen++;
    end
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic odd_of(input logic [7:0] d);
    return ~^d;
  endfunction

  // Device-to-host frame; nbits < 11 sends a truncated frame.
  task automatic dev_send(input logic [7:0] b, input logic flip, input int half,
                          input logic stopb, input int nbits, input logic glitch);
    logic [10:0] bits;
    bits = {stopb, odd_of(b) ^ flip, b, 1'b0};
    for (int k = 0; k < nbits; k++) begin
      tick(half / 2);
      dev_dat_low = ~bits[k];
      if (glitch && k == 4) begin
        tick(5); dev_clk_low = 1'b1; tick(2); dev_clk_low = 1'b0;
        tick(half - half / 2 - 7);
      end else begin
        tick(half - half / 2);
      end
      dev_clk_low = 1'b1;
      tick(half);
      dev_clk_low = 1'b0;
    end
    tick(half / 2);
    dev_dat_low = 1'b0;
  endtask

  // Device side of a host-to-device transfer.
  task automatic dev_recv(input int half, input logic ack, output logic [9:0] got,
                          output int inh_len, output logic start_low);
    int w = 0;
    got = '0;
    while (clk_line && w < 5000) begin tick(1); w++; end
    inh_len = 0;
    while (!clk_line && inh_len < 5000) begin tick(1); inh_len++; end
    start_low = !dat_line;
    tick(20);
    for (int k = 1; k <= 11; k++) begin
      if (k >= 2) got[k-2] = dat_line;
      dev_clk_low = 1'b1; tick(half);
      dev_clk_low = 1'b0; tick(half);
    end
    if (ack) dev_dat_low = 1'b1;
    tick(10);
    dev_clk_low = 1'b1; tick(half);
    dev_clk_low = 1'b0; tick(half);
    dev_dat_low = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_case(input logic [7:0] b, input logic flip, input int half, input logic glitch);
    int n0 = rx_n;
    dev_send(b, flip, half, 1'b1, 11, glitch);
    tick(20);
    chk(rx_n == n0 + 1, "R1 byte count", rx_n - n0, 1);
    chk(rx_last == b, glitch ? "R5 data through glitch" : "R1 data", rx_last, b);
    chk(rx_last_perr == flip, "R2 parity flag", rx_last_perr, flip);
  endtask

  task automatic tx_case(input logic [7:0] b, input int half, input logic overlap);
    logic [9:0] got; int inh; logic sl; int d0 = tx_done_n, t0 = tx_to_n;
    host_send(b);
    chk(tx_ready == 1'b0, "R8 ready low after accept", tx_ready, 0);
    if (overlap) begin
      tx_data = ~b; tx_valid = 1'b1; tick(5); tx_valid = 1'b0;
    end
    dev_recv(half, 1'b1, got, inh, sl);
    tick(20);
    chk(inh >= 100, "R6 inhibit length", inh, 100);
    chk(sl == 1'b1, "R6 start bit low", sl, 1);
    chk(got[7:0] == b, "R7 data bits", got[7:0], b);
    chk(got[8] == odd_of(b), "R7 parity bit", got[8], odd_of(b));
    chk(got[9] == 1'b1, "R7 stop bit", got[9], 1);
    chk(tx_done_n == d0 + 1 && tx_to_n == t0, "R8 done on ack", tx_done_n - d0, 1);
    chk(tx_ready == 1'b1, "R8 ready after ack", tx_ready, 1);
  endtask

  initial begin
    int n0, t0;
    logic [9:0] got; int inh; logic sl;
    void'($urandom(32'd20240611));
    tick(10); rst = 1'b0; tick(20);

    // R11 reset state
    chk(ps2_clk_low_o == 1'b0 && ps2_dat_low_o == 1'b0, "R11 lines released",
        {ps2_clk_low_o, ps2_dat_low_o}, 0);
    chk(tx_ready == 1'b1, "R11 ready", tx_ready, 1);
    chk(pulses_seen == 0, "R11 no pulses", pulses_seen, 0);

    // R1/R2 directed, period boundaries
    rx_case(8'hA5, 1'b0, 40, 1'b0);
    rx_case(8'h00, 1'b1, 40, 1'b0);
    rx_case(8'hFF, 1'b0, 30, 1'b0);
    rx_case(8'h01, 1'b1, 50, 1'b0);

    // R3 bad stop bit
    n0 = rx_n;
    dev_send(8'h6E, 1'b0, 40, 1'b0, 11, 1'b0); tick(20);
    chk(rx_n == n0, "R3 bad stop dropped", rx_n - n0, 0);

    // R4 truncated frame then a good one
    n0 = rx_n; t0 = rx_to_n;
    dev_send(8'h77, 1'b0, 40, 1'b1, 4, 1'b0); tick(RX_TO + 60);
    chk(rx_to_n == t0 + 1, "R4 timeout pulse", rx_to_n - t0, 1);
    chk(rx_n == n0, "R4 partial dropped", rx_n - n0, 0);
    rx_case(8'h77, 1'b0, 40, 1'b0);

    // R5 glitch inside a frame and on the idle line
    rx_case(8'h3C, 1'b0, 40, 1'b1);
    dev_clk_low = 1'b1; tick(2); dev_clk_low = 1'b0; tick(10);
    rx_case(8'hC8, 1'b0, 35, 1'b0);

    // R10 host inhibit
    link_inhibit = 1'b1; tick(15);
    chk(clk_line == 1'b0, "R10 clock held low", clk_line, 0);
    chk(tx_ready == 1'b0, "R10 ready low", tx_ready, 1'b0);
    n0 = rx_n;
    dev_send(8'h42, 1'b0, 40, 1'b1, 11, 1'b0); tick(20);
    chk(rx_n == n0, "R10 no receive", rx_n - n0, 0);
    link_inhibit = 1'b0; tick(30);
    chk(clk_line == 1'b1 && tx_ready == 1'b1, "R10 release", {clk_line, tx_ready}, 3);

    // R6/R7/R8 transmit with a second offer during busy
    tx_case(8'h5A, 40, 1'b1);
    tx_case(8'h80, 30, 1'b0);
    tx_case(8'h00, 50, 1'b0);

    // R9 missing acknowledge
    t0 = tx_to_n; n0 = tx_done_n;
    host_send(8'h81);
    dev_recv(40, 1'b0, got, inh, sl); tick(20);
    chk(tx_to_n == t0 + 1 && tx_done_n == n0, "R9 nack fails", tx_to_n - t0, 1);
    chk(tx_ready == 1'b1, "R9 ready after nack", tx_ready, 1);

    // R9 silent device
    t0 = tx_to_n;
    host_send(8'h19);
    tick(INH + TX_TO + 60);
    chk(tx_to_n == t0 + 1, "R9 edge timeout", tx_to_n - t0, 1);
    chk(tx_ready && !ps2_clk_low_o && !ps2_dat_low_o, "R9 lines released",
        {tx_ready, ps2_clk_low_o, ps2_dat_low_o}, 4);

    // Random mix
    for (int i = 0; i < 12; i++) begin
      rx_case(8'($urandom), 1'($urandom), 30 + int'($urandom % 21), 1'b0);
    end
    for (int i = 0; i < 6; i++) begin
      tx_case(8'($urandom), 30 + int'($urandom % 21), 1'b0);
    end

    summary();
    $finish;
  end
endmodule